// File: doc/BRIEF.md
# Exception Entry Sequencer

This block is the exception entry path of the system-control coprocessor in a 32-bit core with branch delay slots. Each cycle it weighs two kinds of event. One is a synchronous exception that the execute stage raises with a 5-bit cause code. The other is an external interrupt line, which is qualified at the instruction boundary before the next fetch. When either event is accepted, the block writes the cause, status and exception-PC registers. On the following cycle it issues a one-cycle redirect that carries the handler address and the address after it.

The pipeline supplies the address of the instruction in question and a flag that marks it as sitting in a branch delay slot. A second flag marks the instruction as a system call or a breakpoint, whose saved address must point back one instruction. A status write port lets the core load the status register, and this port is what arms the interrupt gate. The block has no stream interface: every pin is a plain control or status signal, and the block has no back-pressure.

Top module: `exc_entry_seq`

## Requirements
- R1: While rst_n is low, cause_q, status_q and epc_q are zero and redir_vld is low.
- R2: On entry, cause_q bits 7:0 are rewritten as {1'b0, code[4:0], 2'b00}, so the code sits in bits 6:2 and bits 7, 1 and 0 read zero.
- R3: A synchronous entry writes the supplied code (overflow 12, system call 8, breakpoint 9), and an interrupt entry writes code 0.
- R4: On entry, cause_q bit 31 is set to in_dslot: it is 1 for an instruction in a delay slot and 0 otherwise.
- R5: On entry, epc_q equals cur_pc, minus 4 when exc_trap is set on a synchronous entry, minus a further 4 when in_dslot is set.
- R6: One cycle after entry, redir_pc is the handler and redir_npc is the handler plus 4. The handler is 0x80000080, or 0xBFC00180 when status bit 22 is 1.
- R7: Cause bit 10 takes the value of ext_irq on every clock edge, and an entry leaves this bit alone.
- R8: An interrupt is accepted only in a cycle with step_en, ext_irq, status bit 0 and status bit 10 all 1. Otherwise the interrupt causes no redirect and leaves epc_q unchanged.
- R9: If an interrupt is accepted in the same cycle as exc_req, the interrupt wins. It records code 0 and takes no system-call adjustment of the EPC.
- R10: On entry, status bits 5:0 shift left by two places, and the new bits 1:0 are zero (kernel mode, interrupts off). All other status bits keep their values.
- R11: status_wr loads status_wdata in a cycle with no entry. If an entry falls in the same cycle, the entry wins and the write is dropped.
- R12: redir_vld is high for exactly the one cycle after each entry. In a cycle with no entry, epc_q holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_en | input | 1 | An instruction is about to be fetched (interrupt check point) |
| exc_req | input | 1 | Synchronous exception request |
| exc_code | input | 5 | Cause code of the synchronous exception |
| exc_trap | input | 1 | Instruction is a system call or breakpoint |
| in_dslot | input | 1 | Instruction sits in a branch delay slot |
| cur_pc | input | 32 | Address of the current instruction |
| ext_irq | input | 1 | External interrupt request |
| status_wr | input | 1 | Status register write strobe |
| status_wdata | input | 32 | Status write value |
| cause_q | output | 32 | Cause register |
| status_q | output | 32 | Status register |
| epc_q | output | 32 | Exception PC register |
| redir_vld | output | 1 | One-cycle redirect pulse |
| redir_pc | output | 32 | New PC |
| redir_npc | output | 32 | New next-PC |

## Verification
Two pairs of events can land on the same clock edge. The first pair is an accepted interrupt and a synchronous exception. The bench raises ext_irq with the gate armed at the same moment as a system-call request. It then expects code 0 and an EPC with no system-call decrement. The second pair is a status write and an entry. The bench drives both on one edge and expects the shifted old status, not the written value. A plain write that follows must then land intact.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int unsigned CODE_W   = 5;
  localparam logic [CODE_W-1:0] CODE_INT  = 5'd0;
  localparam logic [CODE_W-1:0] CODE_SYS  = 5'd8;
  localparam logic [CODE_W-1:0] CODE_BRK  = 5'd9;
  localparam logic [CODE_W-1:0] CODE_OVF  = 5'd12;

  typedef struct packed {
    logic              take;
    logic              is_irq;
    logic [CODE_W-1:0] code;
    logic              trap;
  } entry_t;
endpackage

// File: rtl/exc_irq_gate.sv
module exc_irq_gate
  import exc_entry_pkg::*;
(
  input  logic              step_en,
  input  logic              ext_irq,
  input  logic              ie_cur,
  input  logic              im_line,
  input  logic              exc_req,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              exc_trap,
  output entry_t            entry
);
  logic irq_ok;

  // Interrupt is sampled at the fetch boundary, ahead of the instruction.
  assign irq_ok = step_en & ext_irq & ie_cur & im_line;

  always_comb begin
    entry.take   = irq_ok | exc_req;
    entry.is_irq = irq_ok;
    entry.code   = irq_ok ? CODE_INT : exc_code;
    entry.trap   = irq_ok ? 1'b0 : exc_trap;
  end
endmodule

// File: rtl/exc_target_calc.sv
module exc_target_calc #(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned STEP_BYTES = 4,
  parameter logic [XLEN-1:0] VEC_RUN  = 32'h8000_0080,
  parameter logic [XLEN-1:0] VEC_BOOT = 32'hBFC0_0180
) (
  input  logic [XLEN-1:0] cur_pc,
  input  logic            trap,
  input  logic            dslot,
  input  logic            bev,
  output logic [XLEN-1:0] epc_nxt,
  output logic [XLEN-1:0] vec,
  output logic [XLEN-1:0] vec_nxt
);
  localparam logic [XLEN-1:0] STEP = XLEN'(STEP_BYTES);

  logic [XLEN-1:0] trap_adj;
  logic [XLEN-1:0] slot_adj;

  assign trap_adj = trap  ? STEP : '0;
  assign slot_adj = dslot ? STEP : '0;
  assign epc_nxt  = cur_pc - trap_adj - slot_adj;
  assign vec      = bev ? VEC_BOOT : VEC_RUN;
  assign vec_nxt  = vec + STEP;
endmodule

// File: rtl/exc_status_stack.sv
module exc_status_stack #(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned MODE_LVL = 3
) (
  input  logic [XLEN-1:0] status_q,
  input  logic            take,
  input  logic            wr,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] status_d
);
  localparam int unsigned STK_W = 2 * MODE_LVL;

  logic [XLEN-1:0] pushed;

  generate
    if (XLEN > STK_W) begin : g_hi
      assign pushed[XLEN-1:STK_W] = status_q[XLEN-1:STK_W];
    end
  endgenerate
  assign pushed[STK_W-1:2] = status_q[STK_W-3:0];
  assign pushed[1:0]       = 2'b00;

  always_comb begin
    if (take)    status_d = pushed;
    else if (wr) status_d = wdata;
    else         status_d = status_q;
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned IRQ_BIT    = 10,
  parameter int unsigned BEV_BIT    = 22,
  parameter int unsigned BD_BIT     = 31,
  parameter int unsigned STEP_BYTES = 4,
  parameter int unsigned MODE_LVL   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic              exc_req,
  input  logic [4:0]        exc_code,
  input  logic              exc_trap,
  input  logic              in_dslot,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic              ext_irq,
  input  logic              status_wr,
  input  logic [XLEN-1:0]   status_wdata,
  output logic [XLEN-1:0]   cause_q,
  output logic [XLEN-1:0]   status_q,
  output logic [XLEN-1:0]   epc_q,
  output logic              redir_vld,
  output logic [XLEN-1:0]   redir_pc,
  output logic [XLEN-1:0]   redir_npc
);
  localparam int unsigned CODE_LSB = 2;
  localparam int unsigned CODE_MSB = CODE_LSB + CODE_W - 1;

  entry_t          entry;
  logic [XLEN-1:0] epc_nxt, vec, vec_nxt, status_d;
  logic [XLEN-1:0] cause_d;

  exc_irq_gate u_gate (
    .step_en (step_en),
    .ext_irq (ext_irq),
    .ie_cur  (status_q[0]),
    .im_line (status_q[IRQ_BIT]),
    .exc_req (exc_req),
    .exc_code(exc_code),
    .exc_trap(exc_trap),
    .entry   (entry)
  );

  exc_target_calc #(.XLEN(XLEN), .STEP_BYTES(STEP_BYTES)) u_tgt (
    .cur_pc (cur_pc),
    .trap   (entry.trap),
    .dslot  (in_dslot),
    .bev    (status_q[BEV_BIT]),
    .epc_nxt(epc_nxt),
    .vec    (vec),
    .vec_nxt(vec_nxt)
  );

  exc_status_stack #(.XLEN(XLEN), .MODE_LVL(MODE_LVL)) u_stk (
    .status_q(status_q),
    .take    (entry.take),
    .wr      (status_wr),
    .wdata   (status_wdata),
    .status_d(status_d)
  );

  always_comb begin
    cause_d = cause_q;
    if (entry.take) begin
      cause_d[7:0]               = '0;
      cause_d[CODE_MSB:CODE_LSB] = entry.code;
      cause_d[BD_BIT]            = in_dslot;
    end
    cause_d[IRQ_BIT] = ext_irq;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause_q   <= '0;
      status_q  <= '0;
      epc_q     <= '0;
      redir_vld <= 1'b0;
      redir_pc  <= '0;
      redir_npc <= '0;
    end else begin
      cause_q   <= cause_d;
      status_q  <= status_d;
      redir_vld <= entry.take;
      if (entry.take) begin
        epc_q     <= epc_nxt;
        redir_pc  <= vec;
        redir_npc <= vec_nxt;
      end
    end
  end

  p_npc_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    redir_vld |-> (redir_npc == redir_pc + XLEN'(STEP_BYTES)));

  p_bd_mirror_r4: assert property (@(posedge clk) disable iff (!rst_n)
    redir_vld |-> (cause_q[BD_BIT] == $past(in_dslot)));

  p_code_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    redir_vld |-> (cause_q[1:0] == 2'b00 && cause_q[7] == 1'b0));

  p_stack_push_r10: assert property (@(posedge clk) disable iff (!rst_n)
    redir_vld |-> (status_q[1:0] == 2'b00 && status_q[5:2] == $past(status_q[3:0])));

  p_irq_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && ext_irq && !exc_req && !(status_q[0] && status_q[IRQ_BIT])) |=> !redir_vld);

  p_pending_track_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cause_q[IRQ_BIT] == $past(ext_irq)));

  p_epc_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_en && ext_irq) && !exc_req |=> $stable(epc_q));
endmodule

// File: tb/exc_entry_seq_tb.sv
module exc_entry_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        step_en, exc_req, exc_trap, in_dslot, ext_irq, status_wr;
  logic [4:0]  exc_code;
  logic [31:0] cur_pc, status_wdata;
  logic [31:0] cause_q, status_q, epc_q, redir_pc, redir_npc;
  logic        redir_vld;
  int          n_chk = 0;
  int          n_bad = 0;

  always #5 clk = ~clk;

  exc_entry_seq u_dut (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .exc_req(exc_req),
    .exc_code(exc_code), .exc_trap(exc_trap), .in_dslot(in_dslot),
    .cur_pc(cur_pc), .ext_irq(ext_irq), .status_wr(status_wr),
    .status_wdata(status_wdata), .cause_q(cause_q), .status_q(status_q),
    .epc_q(epc_q), .redir_vld(redir_vld), .redir_pc(redir_pc),
    .redir_npc(redir_npc)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    step_en = 0; exc_req = 0; exc_code = 0; exc_trap = 0; in_dslot = 0;
    cur_pc = 0; ext_irq = 0; status_wr = 0; status_wdata = 0;
  endtask

  task automatic wr_status(input logic [31:0] v);
    @(negedge clk); idle_inputs(); status_wr = 1; status_wdata = v;
    @(negedge clk); idle_inputs();
  endtask

  // one cycle of stimulus, then the next negedge sees the registered result
  task automatic cycle(input logic st, input logic rq, input logic [4:0] cd,
                       input logic tr, input logic ds, input logic [31:0] pc,
                       input logic irq);
    @(negedge clk);
    step_en = st; exc_req = rq; exc_code = cd; exc_trap = tr;
    in_dslot = ds; cur_pc = pc; ext_irq = irq;
    @(negedge clk); idle_inputs();
  endtask

  task automatic t_reset();
    idle_inputs(); rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1 cause", cause_q, 0);
    chk("R1 status", status_q, 0);
    chk("R1 epc", epc_q, 0);
    chk("R1 redir_vld", {31'd0, redir_vld}, 0);
    rst_n = 1;
  endtask

  task automatic t_overflow();
    wr_status(32'h0);
    cycle(1, 1, 5'd12, 0, 0, 32'h0000_1000, 0);
    chk("R2 R3 cause ovf", cause_q, 32'h0000_0030);
    chk("R5 epc plain", epc_q, 32'h0000_1000);
    chk("R12 redir_vld", {31'd0, redir_vld}, 1);
    chk("R6 pc run", redir_pc, 32'h8000_0080);
    chk("R6 npc run", redir_npc, 32'h8000_0084);
    @(negedge clk);
    chk("R12 pulse drops", {31'd0, redir_vld}, 0);
  endtask

  task automatic t_syscall_dslot();
    cycle(1, 1, 5'd8, 1, 1, 32'h0000_2000, 0);
    chk("R3 R4 cause sys dslot", cause_q, 32'h8000_0020);
    chk("R5 epc sys dslot", epc_q, 32'h0000_1FF8);
  endtask

  task automatic t_break_boot();
    wr_status(32'h0040_0000);
    cycle(1, 1, 5'd9, 1, 0, 32'h0000_3000, 0);
    chk("R3 R4 cause brk", cause_q, 32'h0000_0024);
    chk("R5 epc brk", epc_q, 32'h0000_2FFC);
    chk("R6 pc boot", redir_pc, 32'hBFC0_0180);
    chk("R6 npc boot", redir_npc, 32'hBFC0_0184);
    chk("R10 bev kept", status_q, 32'h0040_0000);
  endtask

  task automatic t_stack();
    wr_status(32'h0000_002D);
    cycle(1, 1, 5'd12, 0, 0, 32'h0000_0010, 0);
    chk("R10 status shift", status_q, 32'h0000_0034);
    chk("R5 epc", epc_q, 32'h0000_0010);
  endtask

  task automatic t_irq_gate();
    wr_status(32'h0000_0400);
    cycle(1, 0, 0, 0, 0, 32'h0000_7000, 1);
    chk("R8 no ie", {31'd0, redir_vld}, 0);
    chk("R7 pending set", cause_q & 32'h0000_0400, 32'h0000_0400);
    chk("R8 epc hold", epc_q, 32'h0000_0010);
    @(negedge clk);
    chk("R7 pending clear", cause_q & 32'h0000_0400, 0);
    wr_status(32'h0000_0001);
    cycle(1, 0, 0, 0, 0, 32'h0000_7000, 1);
    chk("R8 no line", {31'd0, redir_vld}, 0);
    wr_status(32'h0000_0401);
    cycle(0, 0, 0, 0, 0, 32'h0000_7000, 1);
    chk("R8 no step", {31'd0, redir_vld}, 0);
    chk("R12 epc hold", epc_q, 32'h0000_0010);
    cycle(1, 0, 0, 0, 1, 32'h0000_4000, 1);
    chk("R8 irq taken", {31'd0, redir_vld}, 1);
    chk("R3 R7 cause irq", cause_q, 32'h8000_0400);
    chk("R5 epc irq dslot", epc_q, 32'h0000_3FFC);
    chk("R10 status irq", status_q, 32'h0000_0404);
    chk("R6 pc irq", redir_pc, 32'h8000_0080);
  endtask

  task automatic t_irq_vs_sync();
    wr_status(32'h0000_0401);
    cycle(1, 1, 5'd8, 1, 0, 32'h0000_5000, 1);
    chk("R9 code int wins", cause_q, 32'h0000_0400);
    chk("R9 epc no trap", epc_q, 32'h0000_5000);
  endtask

  task automatic t_write_vs_entry();
    wr_status(32'h0000_0003);
    @(negedge clk);
    step_en = 1; exc_req = 1; exc_code = 5'd12; cur_pc = 32'h0000_6000;
    status_wr = 1; status_wdata = 32'h0000_003F;
    @(negedge clk); idle_inputs();
    chk("R11 entry wins", status_q, 32'h0000_000C);
    chk("R5 epc", epc_q, 32'h0000_6000);
    wr_status(32'h0000_003F);
    chk("R11 plain write", status_q, 32'h0000_003F);
    chk("R12 no redirect", {31'd0, redir_vld}, 0);
    chk("R12 epc kept", epc_q, 32'h0000_6000);
  endtask

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_overflow();
    t_syscall_dslot();
    t_break_boot();
    t_stack();
    t_irq_gate();
    t_irq_vs_sync();
    t_write_vs_entry();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule